// File: doc/BRIEF.md
# Output Rail Enable Sequencer with Power-Good Window

This block decides when a converter output comes up and goes down, and reports whether it is healthy. A raw enable input is first interpreted through a polarity-select input. When the resolved enable goes true, the block waits a programmable number of ramp ticks and then moves an internal reference code up toward the setpoint by a fixed step on every tick. When the resolved enable goes false, the reference moves back down to zero by a larger fixed step. The step sizes come from the target slew rates (0.1 V/ms rising, 0.5 V/ms falling), the ramp tick rate and the size of one code LSB, so the slews stay correct for any chosen clock.

Once the reference sits exactly on the setpoint, a ramp-done flag is raised and the power-good monitor starts comparing the digitized output sample with a window of 90% to 110% of the setpoint. Power good changes state only after the sample has stayed on the other side of a window edge for a fixed filter time (6 µs by default). Power good is forced low whenever a ramp or delay is in progress, even if the sample happens to lie in the window. The setpoint is assumed to stay constant while the output is enabled.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, ref_out is 0 and pgood and ramp_done are both 0.
- R2: The resolved enable equals en_in when en_active_high is 1 and equals the inverse of en_in when en_active_high is 0; with the resolved enable false, ref_out stays 0.
- R3: With dly_ticks equal to 0, ref_out starts to rise within two ramp tick periods after the resolved enable becomes true.
- R4: With dly_ticks equal to D > 0, ref_out stays 0 for at least D ramp tick periods after the resolved enable becomes true and starts to rise within D+2 tick periods.
- R5: While rising, ref_out changes at most once per ramp tick, by exactly the rising step, except the last change, which lands exactly on setpoint; it never exceeds setpoint.
- R6: ramp_done is 1 only while ref_out equals setpoint after a completed rise, and is 0 during the delay and both ramps.
- R7: When the resolved enable becomes false after the rise, ref_out falls by exactly the falling step per tick (the last change lands on 0) and ramp_done goes to 0.
- R8: If the resolved enable becomes false during the power-up delay, ref_out never leaves 0 and ramp_done stays 0.
- R9: If the resolved enable becomes false during the rise, the next change of ref_out is a fall of the falling step from the value it then holds.
- R10: pgood is 0 throughout the delay, the rise and the fall, even when vout_code lies inside the window.
- R11: The window is inclusive: vout_code counts as good when floor(9*setpoint/10) <= vout_code <= floor(11*setpoint/10).
- R12: pgood changes state only after the in-window result has differed from it for PG filter cycles in a row (6 µs worth of clock cycles); a shorter excursion leaves pgood unchanged; after ramp_done rises with an in-window sample, pgood rises exactly PG cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_in | input | 1 | Raw enable request |
| en_active_high | input | 1 | 1: enable is active high; 0: enable is active low |
| dly_ticks | input | DLY_W | Power-up delay in ramp ticks (0 = none) |
| setpoint | input | CODE_W | Target reference code |
| vout_code | input | CODE_W | Digitized output voltage sample |
| ref_out | output | CODE_W | Ramped reference code |
| pgood | output | 1 | Output is inside the window and settled |
| ramp_done | output | 1 | Reference has reached the setpoint |

## Verification
The bench uses a setpoint that is not a multiple of the rising step, so a ramp that skipped the final clamp would overshoot or stall one step short and never raise ramp_done. It drops the enable both during the delay and mid-rise; a design that ignored the abort would keep climbing or finish the delay and ramp up. It holds the sample exactly on both window limits and one code past each, which catches an exclusive or off-by-one comparison, and it applies an out-of-window excursion one cycle shorter than the filter time, which an unfiltered or short-counted monitor would report as a power-good drop. Power good is watched on every cycle of each ramp with an in-window sample, so a monitor that did not wait for ramp_done would show up at once.

// File: rtl/rail_seq_pkg.sv
// Shared types for the output rail sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package rail_seq_pkg;

    // Sequencer states: off, power-up delay, rising ramp, settled, falling ramp.
    typedef enum logic [2:0] {
        SEQ_OFF  = 3'd0,
        SEQ_WAIT = 3'd1,
        SEQ_RISE = 3'd2,
        SEQ_ON   = 3'd3,
        SEQ_FALL = 3'd4
    } seq_state_e;

    // Command from the sequencer to the reference ramp.
    typedef enum logic [1:0] {
        RMP_HOLD = 2'd0,
        RMP_UP   = 2'd1,
        RMP_DOWN = 2'd2
    } ramp_mode_e;

endpackage

// File: rtl/rail_tick_gen.sv
// Ramp tick prescaler: one-cycle pulse every TICK_DIV clocks.
// Assumes TICK_DIV >= 1; TICK_DIV == 1 gives a tick on every cycle.
module rail_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            logic [CW-1:0] cnt_q;

            // Free-running modulo-TICK_DIV counter.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(TICK_DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == CW'(TICK_DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/rail_seq_fsm.sv
// Enable resolution and sequencing state machine.
// Resolves the raw enable against the polarity select, counts the power-up
// delay in ramp ticks, and commands the reference ramp. Aborts to the falling
// ramp if the enable is lost during the delay or the rise. Assumes the ramp
// reports at_target/at_zero from its registered reference.
module rail_seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic             en_active_high,
    input  logic [DLY_W-1:0] dly_ticks,
    input  logic             tick,
    input  logic             at_target,
    input  logic             at_zero,
    output ramp_mode_e       ramp_mode,
    output logic             ramp_done
);

    seq_state_e       state_q, state_d;
    logic [DLY_W-1:0] dcnt_q, dcnt_d;
    logic             en_eff;

    // Apply the polarity select to the raw enable.
    assign en_eff = en_active_high ? en_in : ~en_in;

    // Next-state and delay-counter logic.
    always_comb begin
        state_d = state_q;
        dcnt_d  = dcnt_q;
        unique case (state_q)
            SEQ_OFF: begin
                if (en_eff) begin
                    if (dly_ticks == '0) begin
                        state_d = SEQ_RISE;
                    end else begin
                        state_d = SEQ_WAIT;
                        dcnt_d  = dly_ticks;
                    end
                end
            end
            SEQ_WAIT: begin
                if (!en_eff) begin
                    state_d = SEQ_FALL;
                end else if (tick) begin
                    if (dcnt_q <= DLY_W'(1)) begin
                        state_d = SEQ_RISE;
                        dcnt_d  = '0;
                    end else begin
                        dcnt_d = dcnt_q - 1'b1;
                    end
                end
            end
            SEQ_RISE: begin
                if (!en_eff) begin
                    state_d = SEQ_FALL;
                end else if (at_target) begin
                    state_d = SEQ_ON;
                end
            end
            SEQ_ON: begin
                if (!en_eff) begin
                    state_d = SEQ_FALL;
                end
            end
            SEQ_FALL: begin
                if (at_zero) begin
                    state_d = SEQ_OFF;
                end
            end
            default: begin
                state_d = SEQ_OFF;
                dcnt_d  = '0;
            end
        endcase
    end

    // State and delay-counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_OFF;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            dcnt_q  <= dcnt_d;
        end
    end

    // Ramp command decode from the present state.
    always_comb begin
        unique case (state_q)
            SEQ_RISE: ramp_mode = RMP_UP;
            SEQ_FALL: ramp_mode = RMP_DOWN;
            default:  ramp_mode = RMP_HOLD;
        endcase
    end

    assign ramp_done = (state_q == SEQ_ON);

endmodule

// File: rtl/rail_ref_ramp.sv
// Reference ramp generator.
// On each tick moves the reference up by UP_STEP (clamped at target) or down
// by DN_STEP (clamped at zero), as commanded. Assumes UP_STEP, DN_STEP >= 1.
module rail_ref_ramp
    import rail_seq_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int UP_STEP = 2,
    parameter int DN_STEP = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  ramp_mode_e        ramp_mode,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] ref_code,
    output logic              at_target,
    output logic              at_zero
);

    logic [CODE_W-1:0] ref_q, ref_d;
    logic [CODE_W-1:0] gap_up;

    assign gap_up = target - ref_q;

    // Compute the next reference code for this tick.
    always_comb begin
        ref_d = ref_q;
        if (tick) begin
            unique case (ramp_mode)
                RMP_UP: begin
                    if (ref_q < target) begin
                        if (gap_up > CODE_W'(UP_STEP)) begin
                            ref_d = ref_q + CODE_W'(UP_STEP);
                        end else begin
                            ref_d = target;
                        end
                    end
                end
                RMP_DOWN: begin
                    if (ref_q > CODE_W'(DN_STEP)) begin
                        ref_d = ref_q - CODE_W'(DN_STEP);
                    end else begin
                        ref_d = '0;
                    end
                end
                default: ref_d = ref_q;
            endcase
        end
    end

    // Reference register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else begin
            ref_q <= ref_d;
        end
    end

    assign ref_code  = ref_q;
    assign at_target = (ref_q == target);
    assign at_zero   = (ref_q == '0);

endmodule

// File: rtl/rail_pg_window.sv
// Power-good window monitor with a consecutive-cycle filter.
// The sample is good when floor(9*sp/10) <= sample <= floor(11*sp/10).
// The flag follows that result only after PG_CYC differing cycles in a row,
// and is cleared at once while eval_en is low. Assumes PG_CYC >= 1.
module rail_pg_window #(
    parameter int CODE_W = 16,
    parameter int PG_CYC = 750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_en,
    input  logic [CODE_W-1:0] setpoint,
    input  logic [CODE_W-1:0] sample,
    output logic              pgood
);

    localparam int PW = CODE_W + 4;

    logic [PW-1:0] sp_w, lo_lim, hi_lim, smp_w;
    logic          in_win, raw_good, pg_q;

    // Window limits at 90% and 110% of the setpoint.
    assign sp_w     = PW'(setpoint);
    assign smp_w    = PW'(sample);
    assign lo_lim   = (sp_w * PW'(9)) / PW'(10);
    assign hi_lim   = (sp_w * PW'(11)) / PW'(10);
    assign in_win   = (smp_w >= lo_lim) && (smp_w <= hi_lim);
    assign raw_good = eval_en && in_win;

    generate
        if (PG_CYC <= 1) begin : g_nofilt
            // Register the window result directly.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pg_q <= 1'b0;
                end else begin
                    pg_q <= raw_good;
                end
            end
        end else begin : g_filt
            localparam int CW = $clog2(PG_CYC + 1);
            logic [CW-1:0] cnt_q;

            // Count consecutive disagreements and flip after PG_CYC of them.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pg_q  <= 1'b0;
                    cnt_q <= '0;
                end else if (!eval_en) begin
                    pg_q  <= 1'b0;
                    cnt_q <= '0;
                end else if (raw_good == pg_q) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(PG_CYC - 1)) begin
                    pg_q  <= raw_good;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

    assign pgood = pg_q;

endmodule

// File: rtl/rail_seq_ctrl.sv
// Output rail enable sequencer and power-good controller (top).
// Derives the tick divider, ramp steps and power-good filter length from the
// clock rate, tick rate, code LSB size and target slews, then ties together
// the tick prescaler, sequencer, reference ramp and window monitor.
// Assumes setpoint is held constant while the output is enabled.
module rail_seq_ctrl #(
    parameter int CODE_W       = 16,
    parameter int DLY_W        = 12,
    parameter int CLK_KHZ      = 125000,
    parameter int TICK_KHZ     = 500,
    parameter int LSB_UV       = 100,
    parameter int UP_UV_PER_MS = 100000,
    parameter int DN_UV_PER_MS = 500000,
    parameter int PG_DELAY_NS  = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_in,
    input  logic              en_active_high,
    input  logic [DLY_W-1:0]  dly_ticks,
    input  logic [CODE_W-1:0] setpoint,
    input  logic [CODE_W-1:0] vout_code,
    output logic [CODE_W-1:0] ref_out,
    output logic              pgood,
    output logic              ramp_done
);
    import rail_seq_pkg::*;

    localparam int TICK_RAW = CLK_KHZ / TICK_KHZ;
    localparam int TICK_DIV = (TICK_RAW < 1) ? 1 : TICK_RAW;
    localparam int UP_RAW   = UP_UV_PER_MS / TICK_KHZ / LSB_UV;
    localparam int DN_RAW   = DN_UV_PER_MS / TICK_KHZ / LSB_UV;
    localparam int UP_STEP  = (UP_RAW < 1) ? 1 : UP_RAW;
    localparam int DN_STEP  = (DN_RAW < 1) ? 1 : DN_RAW;
    localparam int PG_RAW   = (CLK_KHZ * PG_DELAY_NS) / 1000000;
    localparam int PG_CYC   = (PG_RAW < 1) ? 1 : PG_RAW;

    logic       tick, at_target, at_zero;
    ramp_mode_e ramp_mode;

    rail_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rail_seq_fsm #(
        .DLY_W (DLY_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_in          (en_in),
        .en_active_high (en_active_high),
        .dly_ticks      (dly_ticks),
        .tick           (tick),
        .at_target      (at_target),
        .at_zero        (at_zero),
        .ramp_mode      (ramp_mode),
        .ramp_done      (ramp_done)
    );

    rail_ref_ramp #(
        .CODE_W  (CODE_W),
        .UP_STEP (UP_STEP),
        .DN_STEP (DN_STEP)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ramp_mode (ramp_mode),
        .target    (setpoint),
        .ref_code  (ref_out),
        .at_target (at_target),
        .at_zero   (at_zero)
    );

    rail_pg_window #(
        .CODE_W (CODE_W),
        .PG_CYC (PG_CYC)
    ) u_pg (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval_en  (ramp_done),
        .setpoint (setpoint),
        .sample   (vout_code),
        .pgood    (pgood)
    );

endmodule

// File: rtl/rail_seq_ctrl_chk.sv
// Property checker for rail_seq_ctrl, attached by bind.
// Assumes setpoint is constant while ramp_done is high.
module rail_seq_ctrl_chk #(
    parameter int CODE_W  = 16,
    parameter int UP_STEP = 2,
    parameter int DN_STEP = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] setpoint,
    input logic [CODE_W-1:0] ref_out,
    input logic              pgood,
    input logic              ramp_done
);

    // R5
    rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_out > $past(ref_out)) |-> ((ref_out - $past(ref_out)) <= CODE_W'(UP_STEP)));

    // R7
    fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_out < $past(ref_out)) |-> (($past(ref_out) - ref_out) <= CODE_W'(DN_STEP)));

    // R6
    done_at_setpoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |-> (ref_out == setpoint));

    // R10
    pg_low_in_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ramp_done |=> !pgood);

    // R12
    pg_rise_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(ramp_done));

endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk #(
    .CODE_W  (CODE_W),
    .UP_STEP (UP_STEP),
    .DN_STEP (DN_STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .setpoint  (setpoint),
    .ref_out   (ref_out),
    .pgood     (pgood),
    .ramp_done (ramp_done)
);

// File: tb/test_rail_seq_ctrl.sv
module test_rail_seq_ctrl;

    localparam int CODE_W = 16;
    localparam int DLY_W  = 12;
    // Bench parameters: 1000 kHz clock, 250 kHz ticks, 100 uV LSB.
    // Rising 0.1 V/ms -> 400 uV/tick = 4 codes; falling 0.5 V/ms -> 20 codes.
    // Tick every 4 clocks; 6 us at 1 MHz -> 6 filter cycles.
    localparam int DIV = 4;
    localparam int UP  = 4;
    localparam int DN  = 20;
    localparam int PG  = 6;
    localparam int WATCHDOG = 200000;

    localparam int NV = 7;
    localparam int WIN_V [NV] = '{200, 180, 179, 220, 221, 150, 210};
    localparam int WIN_E [NV] = '{1,   1,   0,   1,   0,   0,   1};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              en_in, en_active_high;
    logic [DLY_W-1:0]  dly_ticks;
    logic [CODE_W-1:0] setpoint, vout_code;
    logic [CODE_W-1:0] ref_out;
    logic              pgood, ramp_done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rail_seq_ctrl #(
        .CODE_W   (CODE_W),
        .DLY_W    (DLY_W),
        .CLK_KHZ  (1000),
        .TICK_KHZ (250),
        .LSB_UV   (100)
    ) i_rail_seq_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_in          (en_in),
        .en_active_high (en_active_high),
        .dly_ticks      (dly_ticks),
        .setpoint       (setpoint),
        .vout_code      (vout_code),
        .ref_out        (ref_out),
        .pgood          (pgood),
        .ramp_done      (ramp_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            check(0, "watchdog", cyc, WATCHDOG);
            report();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Track a full rise to sp: step sizes, tick spacing, no overshoot, ramp_done low.
    task automatic track_rise(input int sp, input bit pg_watch);
        int prev = int'(ref_out);
        int last_chg = -1;
        int bad_step = 0, bad_gap = 0, bad_done = 0, bad_pg = 0, maxv = 0;
        for (int t = 0; t < 5000 && !ramp_done; t++) begin
            step(1);
            if (int'(ref_out) != prev) begin
                if (!((int'(ref_out) - prev == UP) ||
                      (int'(ref_out) == sp && int'(ref_out) - prev > 0 && int'(ref_out) - prev < UP)))
                    bad_step++;
                if (last_chg >= 0 && (t - last_chg) != DIV) bad_gap++;
                last_chg = t;
                prev = int'(ref_out);
            end
            if (int'(ref_out) > maxv) maxv = int'(ref_out);
            if (ramp_done && int'(ref_out) != sp) bad_done++;
            if (!ramp_done && int'(ref_out) == sp && int'(ref_out) != 0 && last_chg != t) bad_done++;
            if (pg_watch && pgood) bad_pg++;
        end
        check(bad_step == 0, "R5 rise step size", bad_step, 0);
        check(bad_gap == 0, "R5 rise tick spacing", bad_gap, 0);
        check(maxv == sp, "R5 rise peak equals setpoint", maxv, sp);
        check(ramp_done == 1'b1, "R6 ramp_done at setpoint", int'(ramp_done), 1);
        check(bad_done == 0, "R6 ramp_done only at setpoint", bad_done, 0);
        if (pg_watch) check(bad_pg == 0, "R10 pgood low during rise", bad_pg, 0);
    endtask

    // Track a fall to zero: step sizes, final zero, ramp_done and pgood low.
    task automatic track_fall();
        int prev = int'(ref_out);
        int bad_step = 0, bad_flag = 0;
        for (int t = 0; t < 5000 && ref_out != '0; t++) begin
            step(1);
            if (int'(ref_out) != prev) begin
                if (!((prev - int'(ref_out) == DN) || (ref_out == '0 && prev < DN)))
                    bad_step++;
                prev = int'(ref_out);
            end
            if (t > 1 && (ramp_done || pgood)) bad_flag++;
        end
        check(bad_step == 0, "R7 fall step size", bad_step, 0);
        check(ref_out == '0, "R7 fall ends at zero", int'(ref_out), 0);
        check(bad_flag == 0, "R10 pgood and ramp_done low during fall", bad_flag, 0);
    endtask

    initial begin
        rst_n = 1'b0; en_in = 1'b0; en_active_high = 1'b1;
        dly_ticks = '0; setpoint = 16'd202; vout_code = '0;
        step(5);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check(ref_out == '0, "R1 ref after reset", int'(ref_out), 0);
        check(pgood == 1'b0, "R1 pgood after reset", int'(pgood), 0);
        check(ramp_done == 1'b0, "R1 ramp_done after reset", int'(ramp_done), 0);

        // R2 active-high, input low: nothing happens
        step(20);
        check(ref_out == '0, "R2 active-high with en low stays off", int'(ref_out), 0);
        // R2 active-low, input high: nothing happens
        en_active_high = 1'b0; en_in = 1'b1;
        step(20);
        check(ref_out == '0, "R2 active-low with en high stays off", int'(ref_out), 0);

        // R3 active-low enable with zero delay starts within two ticks
        en_in = 1'b0;
        begin
            int n = 0;
            while (ref_out == '0 && n < 100) begin step(1); n++; end
            check(n <= 2 * DIV, "R3 zero-delay start latency", n, 2 * DIV);
        end
        track_rise(202, 1'b0);
        // R7 disable through active-low polarity
        en_in = 1'b1;
        track_fall();
        en_active_high = 1'b1; en_in = 1'b0;
        step(10);

        // R4 programmed delay with in-window sample; R10 and R12 power-good timing
        setpoint = 16'd200; vout_code = 16'd200; dly_ticks = 12'd10;
        en_in = 1'b1;
        begin
            int n = 0;
            int pg_bad = 0;
            while (ref_out == '0 && n < 500) begin
                step(1); n++;
                if (pgood) pg_bad++;
            end
            check(n >= 10 * DIV, "R4 delay lower bound", n, 10 * DIV);
            check(n <= 12 * DIV, "R4 delay upper bound", n, 12 * DIV);
            check(pg_bad == 0, "R10 pgood low during delay", pg_bad, 0);
        end
        track_rise(200, 1'b1);
        step(PG - 1);
        check(pgood == 1'b0, "R12 pgood not yet high before filter time", int'(pgood), 0);
        step(1);
        check(pgood == 1'b1, "R12 pgood high after filter time", int'(pgood), 1);

        // R11 window table, each vector held past the filter time
        for (int i = 0; i < NV; i++) begin
            vout_code = CODE_W'(WIN_V[i]);
            step(PG + 3);
            check(int'(pgood) == WIN_E[i], $sformatf("R11 window sample %0d", WIN_V[i]),
                  int'(pgood), WIN_E[i]);
        end

        // R12 short excursion ignored, full-length excursion reported
        vout_code = 16'd150;
        step(PG - 1);
        vout_code = 16'd200;
        step(1);
        check(pgood == 1'b1, "R12 short excursion ignored", int'(pgood), 1);
        step(3);
        vout_code = 16'd150;
        step(PG - 1);
        check(pgood == 1'b1, "R12 pgood held until filter time", int'(pgood), 1);
        step(1);
        check(pgood == 1'b0, "R12 pgood drops after filter time", int'(pgood), 0);
        vout_code = 16'd200;
        step(PG + 2);
        check(pgood == 1'b1, "R12 pgood recovers", int'(pgood), 1);

        // R7 normal turn-off from settled state
        en_in = 1'b0;
        step(2);
        check(pgood == 1'b0, "R10 pgood low at start of fall", int'(pgood), 0);
        track_fall();
        step(10);

        // R8 abort during the power-up delay
        dly_ticks = 12'd10;
        en_in = 1'b1;
        step(12);
        en_in = 1'b0;
        begin
            int moved = 0;
            for (int t = 0; t < 100; t++) begin
                step(1);
                if (ref_out != '0 || ramp_done) moved++;
            end
            check(moved == 0, "R8 abort during delay keeps ref at zero", moved, 0);
        end

        // R9 abort during the rise falls from the present value
        dly_ticks = '0;
        en_in = 1'b1;
        begin
            int n = 0;
            int r1, r2;
            while (int'(ref_out) < 40 && n < 500) begin step(1); n++; end
            en_in = 1'b0;
            step(1);
            r1 = int'(ref_out);
            n = 0;
            while (int'(ref_out) == r1 && n < 100) begin step(1); n++; end
            r2 = int'(ref_out);
            check(r2 == r1 - DN, "R9 abort during rise falls by one step", r2, r1 - DN);
            check(ramp_done == 1'b0, "R9 ramp_done low after abort", int'(ramp_done), 0);
        end
        track_fall();

        report();
    end

endmodule